// File: doc/BRIEF.md
# Local-Aware Interrupt Priority Selector

This block decides which interrupt a hart takes next. It gets three 64-bit vectors: pending, enable and a privilege-derived mask. In all three vectors the bit position is the exception code. It also gets a non-maskable request and a width-mode select, where high selects 64-bit operation and low selects 32-bit operation. From these it produces a take flag, a non-maskable flag and a 6-bit exception code.

Platform-local interrupts use codes 16 and above. They rank above all nine standard software, timer and external interrupts. Among the local interrupts, the higher code wins. The width mode sets how many local codes can compete.

The selection logic holds no state. A parameter adds one output register stage for timing closure. The surrounding trap logic reads the outputs and handles entry. Mask generation and CSR access are done elsewhere.

Top module: `irq_prio_sel`

## Requirements
- R1: An interrupt code is a candidate only when its pending, enable and mask bits are all 1. If any of the three is 0, that code cannot win.
- R2: While `nmi_req_i` is 1, `nmi_o` and `take_o` are 1 and `code_o` is 0, whatever the other vectors hold. While `nmi_req_i` is 0, `nmi_o` is 0.
- R3: Any local candidate (code 16 or above) beats every standard candidate (code 15 or below).
- R4: Among local candidates, the one with the highest code wins.
- R5: When `wide_mode_i` is 1, local codes 16 to 63 compete. When it is 0, only codes 16 to 31 compete, and bits 32 to 63 have no effect.
- R6: Among standard candidates, the winner follows this order from highest to lowest: 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R7: Bits 2, 6, 10 and 12 to 15 are not interrupt codes and never win.
- R8: When there is no candidate and no non-maskable request, `take_o`, `nmi_o` and `code_o` are all 0.
- R9: With `REG_OUT`=0, the outputs follow the inputs in the same cycle, and a change of `wide_mode_i` shows at once. With `REG_OUT`=1, the outputs show the result for the inputs of the previous clock edge, and they read 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the optional output stage and the checks) |
| rst_n | input | 1 | Active-low reset of the optional output stage |
| pend_i | input | 64 | Pending bits, indexed by exception code |
| en_i | input | 64 | Enable bits, indexed by exception code |
| mask_i | input | 64 | Privilege-derived mask bits, indexed by exception code |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| wide_mode_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| take_o | output | 1 | An interrupt should be taken |
| nmi_o | output | 1 | The winner is the non-maskable interrupt |
| code_o | output | 6 | Exception code of the winning maskable interrupt |

## Verification
The assertions sample at the rising clock edge. They assume every input is stable across that edge and holds a known value once reset is released. The bench meets this by changing every input one time unit after a rising edge and reading the outputs at the falling edge. The assertions also assume that the mask vector was produced outside the block and may hold any pattern. For that reason the stimulus includes reserved bit positions and local bits above 31 in both modes. It also includes mode flips between consecutive cycles while the same vectors are held.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  localparam int VEC_W_DEF    = 64;
  localparam int NARROW_W_DEF = 32;
  localparam int LOCAL_BASE   = 16;
  localparam int STD_N        = 9;

  // Standard interrupt ranking: rank 0 is the strongest.
  function automatic int std_rank_code(input int rank);
    case (rank)
      0:       return 11;
      1:       return 3;
      2:       return 7;
      3:       return 9;
      4:       return 1;
      5:       return 5;
      6:       return 8;
      7:       return 0;
      default: return 4;
    endcase
  endfunction

  // Number of local slots that take part for a given mode.
  function automatic int live_local_slots(input int vec_w, input int narrow_w,
                                          input logic wide);
    return wide ? (vec_w - LOCAL_BASE) : (narrow_w - LOCAL_BASE);
  endfunction

endpackage

// File: rtl/irqsel_cand.sv
module irqsel_cand #(
  parameter int VEC_W      = 64,
  parameter int NARROW_W   = 32,
  parameter int LOCAL_BASE = 16,
  localparam int LOC_W     = VEC_W - LOCAL_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VEC_W-1:0]      pend_i,
  input  logic [VEC_W-1:0]      en_i,
  input  logic [VEC_W-1:0]      mask_i,
  input  logic                  wide_i,
  output logic [LOCAL_BASE-1:0] std_cand_o,
  output logic [LOC_W-1:0]      loc_cand_o
);

  logic [VEC_W-1:0] armed;
  assign armed = pend_i & en_i & mask_i;

  assign std_cand_o = armed[LOCAL_BASE-1:0];

  // Local slots above the narrow limit only count in wide mode.
  for (genvar g = 0; g < LOC_W; g++) begin : g_loc
    if (g + LOCAL_BASE < NARROW_W) begin : g_always
      assign loc_cand_o[g] = armed[g + LOCAL_BASE];
    end else begin : g_wide_only
      assign loc_cand_o[g] = armed[g + LOCAL_BASE] & wide_i;
    end
  end

  // R1: a candidate needs all three qualifying bits.
  a_r1_cand_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (|loc_cand_o) |-> (|(pend_i[VEC_W-1:LOCAL_BASE] & en_i[VEC_W-1:LOCAL_BASE]
                        & mask_i[VEC_W-1:LOCAL_BASE])));

endmodule

// File: rtl/irqsel_local.sv
module irqsel_local #(
  parameter int LOC_W      = 48,
  parameter int LOCAL_BASE = 16,
  parameter int CODE_W     = 6,
  localparam int IDX_W     = (LOC_W > 1) ? $clog2(LOC_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOC_W-1:0]  loc_cand_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);

  logic [IDX_W-1:0] win_idx;

  // Scan upward so the last set slot, the highest one, is kept.
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < LOC_W; i++) begin
      if (loc_cand_i[i]) win_idx = IDX_W'(i);
    end
  end

  assign hit_o  = |loc_cand_i;
  assign code_o = hit_o ? CODE_W'(int'(win_idx) + LOCAL_BASE) : '0;

  // R4: the chosen slot is set and nothing above it is.
  a_r4_local_highest: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (loc_cand_i[win_idx] && (((loc_cand_i >> win_idx) >> 1) == '0)));

  a_r3_local_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (code_o >= CODE_W'(LOCAL_BASE)));

endmodule

// File: rtl/irqsel_std.sv
module irqsel_std #(
  parameter int STD_W  = 16,
  parameter int CODE_W = 6,
  localparam int RANKS = irqsel_pkg::STD_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STD_W-1:0]  std_cand_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);

  logic [RANKS-1:0] req;
  logic [RANKS-1:0] grant;
  logic [RANKS:0]   blocked;

  assign blocked[0] = 1'b0;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    localparam int C = irqsel_pkg::std_rank_code(r);
    assign req[r]       = std_cand_i[C];
    assign grant[r]     = req[r] & ~blocked[r];
    assign blocked[r+1] = blocked[r] | req[r];
  end

  assign hit_o = blocked[RANKS];

  always_comb begin
    code_o = '0;
    for (int r = 0; r < RANKS; r++) begin
      if (grant[r]) code_o = code_o | CODE_W'(irqsel_pkg::std_rank_code(r));
    end
  end

  // R6: at most one rank is granted, and exactly one when any is requested.
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r6_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(grant) == 1));

  // R7: reserved positions never produce a code.
  a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (code_o != 2 && code_o != 6 && code_o != 10 && code_o < 12));

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int VEC_W      = irqsel_pkg::VEC_W_DEF,
  parameter int NARROW_W   = irqsel_pkg::NARROW_W_DEF,
  parameter bit REG_OUT    = 1'b0,
  localparam int LOCAL_BASE = irqsel_pkg::LOCAL_BASE,
  localparam int LOC_W     = VEC_W - LOCAL_BASE,
  localparam int CODE_W    = $clog2(VEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  pend_i,
  input  logic [VEC_W-1:0]  en_i,
  input  logic [VEC_W-1:0]  mask_i,
  input  logic              nmi_req_i,
  input  logic              wide_mode_i,
  output logic              take_o,
  output logic              nmi_o,
  output logic [CODE_W-1:0] code_o
);

  logic [LOCAL_BASE-1:0] std_cand;
  logic [LOC_W-1:0]      loc_cand;
  logic                  loc_hit;
  logic                  std_hit;
  logic [CODE_W-1:0]     loc_code;
  logic [CODE_W-1:0]     std_code;

  logic                  sel_take;
  logic                  sel_nmi;
  logic [CODE_W-1:0]     sel_code;

  irqsel_cand #(
    .VEC_W(VEC_W), .NARROW_W(NARROW_W), .LOCAL_BASE(LOCAL_BASE)
  ) u_cand (
    .clk(clk), .rst_n(rst_n),
    .pend_i(pend_i), .en_i(en_i), .mask_i(mask_i), .wide_i(wide_mode_i),
    .std_cand_o(std_cand), .loc_cand_o(loc_cand)
  );

  irqsel_local #(
    .LOC_W(LOC_W), .LOCAL_BASE(LOCAL_BASE), .CODE_W(CODE_W)
  ) u_local (
    .clk(clk), .rst_n(rst_n),
    .loc_cand_i(loc_cand), .hit_o(loc_hit), .code_o(loc_code)
  );

  irqsel_std #(
    .STD_W(LOCAL_BASE), .CODE_W(CODE_W)
  ) u_std (
    .clk(clk), .rst_n(rst_n),
    .std_cand_i(std_cand), .hit_o(std_hit), .code_o(std_code)
  );

  // Final merge: non-maskable first, then local, then standard.
  always_comb begin
    sel_nmi  = nmi_req_i;
    sel_take = nmi_req_i | loc_hit | std_hit;
    if (nmi_req_i)    sel_code = '0;
    else if (loc_hit) sel_code = loc_code;
    else if (std_hit) sel_code = std_code;
    else              sel_code = '0;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        take_o <= 1'b0;
        nmi_o  <= 1'b0;
        code_o <= '0;
      end else begin
        take_o <= sel_take;
        nmi_o  <= sel_nmi;
        code_o <= sel_code;
      end
    end

    a_r9_reg_nmi_delay: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req_i |=> (nmi_o && take_o));
  end else begin : g_comb
    assign take_o = sel_take;
    assign nmi_o  = sel_nmi;
    assign code_o = sel_code;

    a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req_i |-> (nmi_o && take_o && code_o == '0));

    a_r3_local_over_std: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_hit && !nmi_req_i) |-> (code_o >= CODE_W'(LOCAL_BASE)));

    a_r5_narrow_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_mode_i && take_o && !nmi_o) |-> (code_o < CODE_W'(NARROW_W)));
  end

  // R8: an idle result is all zero; R2: the flag never comes alone with a code.
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (!nmi_o && code_o == '0));

  a_r2_nmi_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> (take_o && code_o == '0));

endmodule

// File: tb/irq_prio_sel_test.sv
module irq_prio_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pend = '0, en = '0, msk = '0;
  logic        nmi = 1'b0, wide = 1'b1;
  logic        take_c, nmi_c, take_r, nmi_r;
  logic [5:0]  code_c, code_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] prev_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_sel #(.REG_OUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .mask_i(msk),
    .nmi_req_i(nmi), .wide_mode_i(wide),
    .take_o(take_c), .nmi_o(nmi_c), .code_o(code_c)
  );

  irq_prio_sel #(.REG_OUT(1'b1)) uut_reg (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .mask_i(msk),
    .nmi_req_i(nmi), .wide_mode_i(wide),
    .take_o(take_r), .nmi_o(nmi_r), .code_o(code_r)
  );

  localparam int STD_ORD[9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};

  // Expected {take, nmi, code} from the requirements.
  function automatic logic [7:0] ref_of(input logic [63:0] p, input logic [63:0] e,
                                        input logic [63:0] m, input logic n,
                                        input logic w);
    logic [63:0] c;
    if (n) return {2'b11, 6'd0};
    c = p & e & m;
    for (int k = (w ? 63 : 31); k >= 16; k--)
      if (c[k]) return {2'b10, 6'(k)};
    for (int k = 0; k < 9; k++)
      if (c[STD_ORD[k]]) return {2'b10, 6'(STD_ORD[k])};
    return 8'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual take=%b nmi=%b code=%0d, expected take=%b nmi=%b code=%0d",
               tag, act[7], act[6], act[5:0], exp[7], exp[6], exp[5:0]);
    end
  endtask

  task automatic apply(input logic [63:0] p, input logic [63:0] e, input logic [63:0] m,
                       input logic n, input logic w, input string tag);
    @(posedge clk);
    #1;
    pend = p; en = e; msk = m; nmi = n; wide = w;
    exp_q.push_back(ref_of(p, e, m, n, w));
    tag_q.push_back(tag);
  endtask

  // Monitor: same-cycle result for uut, previous item for uut_reg (R9).
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {take_c, nmi_c, code_c}, e);
      check({"R9 registered stage, ", t}, {take_r, nmi_r, code_r}, prev_exp);
      prev_exp = e;
    end
  end

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] all_std;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset idle", {take_c, nmi_c, code_c}, 8'd0);
    check("R9 reset clears registered stage", {take_r, nmi_r, code_r}, 8'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    apply('0, '0, '0, 1'b0, 1'b1, "R8 nothing pending");
    // R1: each qualifier alone or missing one
    apply(64'h800, '0, '0, 1'b0, 1'b1, "R1 pending only");
    apply(64'h800, 64'h800, '0, 1'b0, 1'b1, "R1 no mask");
    apply(64'h800, '0, 64'h800, 1'b0, 1'b1, "R1 no enable");
    apply(64'h800, 64'h800, 64'h800, 1'b0, 1'b1, "R1 all three set");
    // R2
    apply('1, '1, '1, 1'b1, 1'b1, "R2 nmi over everything");
    apply('0, '0, '0, 1'b1, 1'b0, "R2 nmi alone");
    // R3
    apply(64'h1_0800, '1, '1, 1'b0, 1'b1, "R3 local 16 beats 11");
    // R4 / R5 / R9 mode flip
    all_std = (64'd1 << 20) | (64'd1 << 40) | (64'd1 << 17);
    apply(all_std, '1, '1, 1'b0, 1'b1, "R4 highest local wins wide");
    apply(all_std, '1, '1, 1'b0, 1'b0, "R5 R9 narrow mode change");
    apply(all_std, '1, '1, 1'b0, 1'b1, "R9 back to wide");
    apply(64'd1 << 50, '1, '1, 1'b0, 1'b0, "R5 local 50 ignored narrow");
    apply((64'd1 << 50) | 64'h8, '1, '1, 1'b0, 1'b0, "R5 narrow falls to standard");
    apply(64'd1 << 63, '1, '1, 1'b0, 1'b1, "R5 local 63 wide");
    apply(64'd1 << 31, '1, '1, 1'b0, 1'b0, "R5 local 31 narrow");
    // R6: drop the winner one rank at a time
    all_std = 64'h0BBB;
    for (int k = 0; k < 9; k++) begin
      apply(all_std, '1, '1, 1'b0, 1'b1, "R6 standard order");
      all_std[STD_ORD[k]] = 1'b0;
    end
    // R7
    apply(64'hF444, '1, '1, 1'b0, 1'b1, "R7 reserved bits only");
    apply(64'hF454, '1, '1, 1'b0, 1'b1, "R7 reserved with user timer");
    // mixed patterns
    for (int i = 0; i < 200; i++) begin
      apply({$urandom, $urandom} & {$urandom, $urandom},
            {$urandom, $urandom} | {$urandom, $urandom},
            {$urandom, $urandom}, ($urandom % 16) == 0, $urandom % 2,
            "R3 R4 R6 mixed pattern");
    end
    apply('0, '0, '0, 1'b0, 1'b1, "R8 idle again");
    apply('0, '0, '0, 1'b0, 1'b1, "R8 idle flush");

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule